// File: doc/BRIEF.md
# Pointer Tag Masking and Canonical Address Check

This block sits between a load/store address generator and the address translation logic. Each cycle it can accept one 64-bit virtual pointer together with the privilege of the access. It returns either a canonical linear address with the tag bits cleaned out, or a general-protection fault flag with a cause code. The result is registered, and there is a valid/ready handshake on both sides.

The pointer's bit 63 sets its class: user when clear, supervisor when set. Masking of the upper (tag) bits can be enabled separately for each class. The top implemented address bit is 47 in the narrow translation mode and 56 in the wide mode. A legacy option lets user-privilege accesses also ignore bit 63. In that case the class comes from the top implemented bit, so a tagged user pointer is never mistaken for a kernel pointer. Ignored bits are replaced by copies of the reference sign bit, so the downstream logic only ever sees canonical values.

Top module: `addr_tag_check`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A pointer accepted on a rising edge (`in_valid` and `in_ready` both high) appears on the outputs with `out_valid`=1 after that same edge, which is a latency of one cycle. `in_ready` equals `!out_valid || out_ready`.
- R3: With masking off for the pointer's class, the pointer is canonical only when bits 63 down to T are all equal. T is 47 when `cfg_wide`=0 and 56 when `cfg_wide`=1. A non-canonical pointer gives `out_fault`=1 with `out_cause`=1. With masking off, `out_addr` equals the input pointer.
- R4: With `cfg_mask_user`=1 and bit 63 clear, bits 62 down to T+1 are ignored. Only bit T must equal bit 63. Those ignored bits read as 0 in `out_addr`.
- R5: With `cfg_mask_sup`=1 and bit 63 set, the same rule applies. The ignored bits read as 1 in `out_addr`, and bit 63 is passed through.
- R6: The boundary T follows `cfg_wide`. A tag in bits 56..48 is allowed only in narrow mode. A tag in bits 62..57 is allowed in both modes.
- R7: A canonical pointer of supervisor class used with `in_priv`=0 (user) faults with `out_cause`=2. With `in_priv`=1, no fault is raised.
- R8: When a pointer is both non-canonical and a user access to a supervisor-class pointer, the cause is 1.
- R9: When `cfg_mask_top`=1, `cfg_mask_user`=1 and `in_priv`=0, bits 63 down to T+1 are all ignored. The class is taken from bit T, and `out_addr` is the pointer sign-extended from bit T. For supervisor accesses, `cfg_mask_top` has no effect.
- R10: `out_fault` is 1 exactly when `out_cause` is non-zero. Cause 0 means no fault. A result without a fault always has `out_addr` bits 63..56 all equal.
- R11: While `out_valid`=1 and `out_ready`=0, the outputs hold their values and no new pointer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pointer offered |
| in_ready | output | 1 | Stage can take a pointer |
| in_addr | input | 64 | Virtual pointer |
| in_priv | input | 1 | Access privilege, 1 = supervisor |
| cfg_mask_user | input | 1 | Enable tag masking for user-class pointers |
| cfg_mask_sup | input | 1 | Enable tag masking for supervisor-class pointers |
| cfg_wide | input | 1 | 1 = 57-bit addresses (T=56), 0 = 48-bit (T=47) |
| cfg_mask_top | input | 1 | Legacy mode: user accesses also ignore bit 63 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Masked canonical linear address |
| out_fault | output | 1 | General-protection fault |
| out_cause | output | 2 | 0 none, 1 non-canonical, 2 user access to supervisor pointer |

## Verification
The properties assume that `in_valid`, the configuration and the pointer are never unknown while reset is low. They also assume that the consumer drives `out_ready` to a known level on every edge. The configuration may change between pointers, because no property ties a result to the configuration that was present at capture time. The stimulus drives every input at the falling edge from known values. It changes the configuration only while no pointer is waiting to be captured, and it builds pointers whose upper bits are either uniform or have a single flipped bit, so that every boundary is reached.

// File: rtl/addr_chk_pkg.sv
package addr_chk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NONCANON = 2'd1,
    CAUSE_PRIV     = 2'd2
  } cause_e;
endpackage

// File: rtl/addr_chk_sel.sv
// Decides which address bits are ignored, which must match the reference
// sign bit, and which privilege class the pointer belongs to.
module addr_chk_sel #(
  parameter int ADDR_W     = 64,
  parameter int NARROW_TOP = 47,
  parameter int WIDE_TOP   = 56
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic              mask_user,
  input  logic              mask_sup,
  input  logic              wide,
  input  logic              mask_top,
  output logic [ADDR_W-1:0] ign,
  output logic [ADDR_W-1:0] chk,
  output logic              ref_bit,
  output logic              cls
);
  localparam int MSB = ADDR_W - 1;

  logic [ADDR_W-1:0] above_n, above_w, at_n, at_w;
  logic [ADDR_W-1:0] above, at_top, msb_only;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bnd
    assign above_n[g]  = (g > NARROW_TOP) ? 1'b1 : 1'b0;
    assign above_w[g]  = (g > WIDE_TOP)   ? 1'b1 : 1'b0;
    assign at_n[g]     = (g == NARROW_TOP) ? 1'b1 : 1'b0;
    assign at_w[g]     = (g == WIDE_TOP)   ? 1'b1 : 1'b0;
    assign msb_only[g] = (g == MSB)        ? 1'b1 : 1'b0;
  end

  logic top_bit, alt, men;

  always_comb begin
    above   = wide ? above_w : above_n;
    at_top  = wide ? at_w : at_n;
    top_bit = wide ? addr[WIDE_TOP] : addr[NARROW_TOP];
    alt     = mask_top && !priv && mask_user;
    cls     = alt ? top_bit : addr[MSB];
    men     = cls ? mask_sup : mask_user;
    ref_bit = alt ? top_bit : addr[MSB];
    if (alt)      ign = above;
    else if (men) ign = above & ~msb_only;
    else          ign = '0;
    chk = (above | at_top) & ~ign;
  end
endmodule

// File: rtl/addr_chk_canon.sv
// Per-bit mismatch detection and tag replacement.
module addr_chk_canon #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ign,
  input  logic [ADDR_W-1:0] chk,
  input  logic              ref_bit,
  output logic [ADDR_W-1:0] lin_addr,
  output logic              noncanon
);
  logic [ADDR_W-1:0] mism;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    assign mism[g]     = chk[g] & (addr[g] ^ ref_bit);
    assign lin_addr[g] = ign[g] ? ref_bit : addr[g];
  end

  assign noncanon = |mism;
endmodule

// File: rtl/addr_chk_reg.sv
// One-entry output register with valid/ready flow control.
module addr_chk_reg #(
  parameter int W = 67
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end
endmodule

// File: rtl/addr_tag_check.sv
module addr_tag_check #(
  parameter int ADDR_W     = 64,
  parameter int NARROW_TOP = 47,
  parameter int WIDE_TOP   = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_priv,
  input  logic              cfg_mask_user,
  input  logic              cfg_mask_sup,
  input  logic              cfg_wide,
  input  logic              cfg_mask_top,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_fault,
  output logic [1:0]        out_cause
);
  import addr_chk_pkg::*;

  localparam int PW = ADDR_W + 3;

  logic [ADDR_W-1:0] ign, chk, lin;
  logic ref_bit, cls, noncanon;
  cause_e cause;
  logic fault;

  addr_chk_sel #(.ADDR_W(ADDR_W), .NARROW_TOP(NARROW_TOP), .WIDE_TOP(WIDE_TOP)) u_sel (
    .addr(in_addr), .priv(in_priv), .mask_user(cfg_mask_user), .mask_sup(cfg_mask_sup),
    .wide(cfg_wide), .mask_top(cfg_mask_top), .ign(ign), .chk(chk),
    .ref_bit(ref_bit), .cls(cls)
  );

  addr_chk_canon #(.ADDR_W(ADDR_W)) u_canon (
    .addr(in_addr), .ign(ign), .chk(chk), .ref_bit(ref_bit),
    .lin_addr(lin), .noncanon(noncanon)
  );

  always_comb begin
    if (noncanon)            cause = CAUSE_NONCANON;
    else if (cls && !in_priv) cause = CAUSE_PRIV;
    else                     cause = CAUSE_NONE;
    fault = (cause != CAUSE_NONE);
  end

  logic [PW-1:0] pay_in, pay_out;
  assign pay_in = {fault, cause, lin};

  addr_chk_reg #(.W(PW)) u_reg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(pay_in), .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign out_fault = pay_out[PW-1];
  assign out_cause = pay_out[PW-2:PW-3];
  assign out_addr  = pay_out[ADDR_W-1:0];
endmodule

// File: rtl/addr_tag_check_props.sv
module addr_tag_check_props #(
  parameter int ADDR_W   = 64,
  parameter int WIDE_TOP = 56
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_fault,
  input logic [1:0]        out_cause
);
  logic [ADDR_W-1:WIDE_TOP] hi;
  assign hi = out_addr[ADDR_W-1:WIDE_TOP];

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) $past(rst) |-> !out_valid);
  // R2
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
                                   $stable(out_fault) && $stable(out_cause)));
  // R11
  a_r11_no_accept: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R10
  a_r10_fault_code: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_fault == (out_cause != 2'd0)));
  // R10
  a_r10_canon_out: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |-> ((&hi) || !(|hi)));
  // R8, R10
  a_r8_cause_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cause != 2'd3));
endmodule

bind addr_tag_check addr_tag_check_props #(.ADDR_W(ADDR_W), .WIDE_TOP(WIDE_TOP)) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_fault(out_fault), .out_cause(out_cause)
);

// File: tb/sim_addr_tag_check.sv
`timescale 1ns/1ps
module sim_addr_tag_check;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, in_priv = 1'b0;
  logic [63:0] in_addr = '0;
  logic cfg_mask_user = 1'b0, cfg_mask_sup = 1'b0, cfg_wide = 1'b0, cfg_mask_top = 1'b0;
  logic out_valid, out_ready = 1'b1, out_fault;
  logic [63:0] out_addr;
  logic [1:0] out_cause;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_tag_check u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_priv(in_priv), .cfg_mask_user(cfg_mask_user), .cfg_mask_sup(cfg_mask_sup),
    .cfg_wide(cfg_wide), .cfg_mask_top(cfg_mask_top), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_fault(out_fault), .out_cause(out_cause)
  );

  task automatic chk(input bit ok, input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns {fault, cause[1:0], addr[63:0]}
  function automatic logic [66:0] model(input logic [63:0] a, input logic pv,
      input logic mu, input logic ms, input logic wd, input logic mt);
    int t;
    logic cls, me, nc;
    logic [63:0] o;
    logic [1:0] c;
    t = wd ? 56 : 47;
    o = a;
    nc = 1'b0;
    if (mt && !pv && mu) begin
      cls = a[t];
      for (int i = t + 1; i < 64; i++) o[i] = a[t];
    end else begin
      cls = a[63];
      me = cls ? ms : mu;
      if (me) begin
        nc = (a[t] != a[63]);
        for (int i = t + 1; i < 63; i++) o[i] = a[63];
      end else begin
        for (int i = t; i < 63; i++) if (a[i] != a[63]) nc = 1'b1;
      end
    end
    c = nc ? 2'd1 : ((cls && !pv) ? 2'd2 : 2'd0);
    return {c != 2'd0, c, o};
  endfunction

  task automatic run(input logic [63:0] a, input logic pv, input logic mu, input logic ms,
      input logic wd, input logic mt, input string tag);
    logic [66:0] e;
    @(negedge clk);
    cfg_mask_user = mu; cfg_mask_sup = ms; cfg_wide = wd; cfg_mask_top = mt;
    in_addr = a; in_priv = pv; in_valid = 1'b1;
    e = model(a, pv, mu, ms, wd, mt);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {tag, " R2 valid"}, {66'd0, out_valid}, 67'd1);
    chk({out_fault, out_cause, out_addr} === e, tag, {out_fault, out_cause, out_addr}, e);
  endtask

  function automatic logic [63:0] rand_ptr();
    logic [63:0] a;
    int k;
    a = {$urandom, $urandom};
    k = $urandom_range(0, 4);
    if (k < 2) a[63:47] = (k == 0) ? '0 : '1;
    else if (k < 4) begin
      a[63:47] = (k == 2) ? '0 : '1;
      a[$urandom_range(47, 63)] ^= 1'b1;
    end
    return a;
  endfunction

  initial begin
    logic [66:0] ea;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 in reset", {65'd0, out_valid, in_ready}, 67'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after reset", {65'd0, out_valid, in_ready}, 67'd1);

    // directed corners
    run(64'h0000_7fff_ffff_f000, 0, 0, 0, 0, 0, "R3 canonical user");
    run(64'h0000_8000_0000_0000, 0, 0, 0, 0, 0, "R3 bit47 set, noncanon");
    run(64'h0100_0000_0000_1000, 0, 0, 0, 0, 0, "R3 unmasked tag faults");
    run(64'h7f00_1234_5678_9abc, 0, 1, 0, 0, 0, "R4 user tag masked");
    run(64'h7f00_9234_5678_9abc, 0, 1, 0, 0, 0, "R4 bit47 mismatch");
    run(64'h8a00_ffff_0000_0040, 1, 0, 1, 0, 0, "R5 sup tag masked");
    run(64'h8a00_ffff_0000_0040, 1, 1, 0, 0, 0, "R5 sup mask off faults");
    run(64'h0123_0000_0000_0000, 0, 1, 0, 1, 0, "R6 wide, tag in 56..48 noncanon");
    run(64'h7e00_0000_0000_0000, 0, 1, 0, 1, 0, "R6 wide, tag in 62..57 ok");
    run(64'hffff_8000_0000_0000, 0, 0, 0, 0, 0, "R7 user to sup pointer");
    run(64'hffff_8000_0000_0000, 1, 0, 0, 0, 0, "R7 sup access ok");
    run(64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, "R8 priority noncanon");
    run(64'hc500_1234_0000_0008, 0, 1, 0, 0, 1, "R9 top masked user");
    run(64'hc500_f234_0000_0008, 0, 1, 0, 0, 1, "R9 class from bit T");
    run(64'hffff_8000_0000_0000, 1, 1, 0, 0, 1, "R9 no effect for sup");

    // R11 backpressure
    @(negedge clk);
    out_ready = 1'b0;
    cfg_mask_user = 0; cfg_mask_sup = 0; cfg_wide = 0; cfg_mask_top = 0; in_priv = 1;
    in_addr = 64'h0000_0000_0000_1111; in_valid = 1'b1;
    ea = model(64'h0000_0000_0000_1111, 1, 0, 0, 0, 0);
    @(negedge clk);
    chk(out_valid === 1'b1 && in_ready === 1'b0, "R11 stall ready low", {65'd0, out_valid, in_ready}, 67'd2);
    in_addr = 64'hffff_ffff_ffff_2222;
    @(negedge clk);
    chk({out_fault, out_cause, out_addr} === ea, "R11 held", {out_fault, out_cause, out_addr}, ea);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ea = model(64'hffff_ffff_ffff_2222, 1, 0, 0, 0, 0);
    chk(out_valid === 1'b1 && {out_fault, out_cause, out_addr} === ea, "R11 next after release",
        {out_fault, out_cause, out_addr}, ea);

    // random
    for (int n = 0; n < 600; n++) begin
      logic [3:0] m;
      m = 4'($urandom);
      run(rand_ptr(), 1'($urandom), m[0], m[1], m[2], m[3], "R10 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule